// File: doc/BRIEF.md
# Complementary PWM Dead-Time and Pattern Stage

This block takes up to four compare-channel waveform bits from a timer and turns each one into a pair of pin drives: a low-side drive that follows the waveform and a high-side drive that is its complement. Whenever the waveform toggles, the drive that is switching off drops on the next clock. The drive that is switching on waits a programmable number of clocks first. Rising and falling transitions each have their own 8-bit count. The low-side count governs how long the low-side drive waits after a rise. The high-side count governs how long the high-side drive waits after a fall.

A pattern mode bypasses the dead-time path. In this mode the waveform of channel 0 is copied onto any subset of the eight pins, selected by a pattern mask. Software writes the dead-time pair and the pattern mask into holding registers. The timer's update strobe moves them into the active registers, so a new setting always starts at a period boundary.

A set of fault lines, each gated by a mask, forces every pin drive to 0 in the same cycle the fault arrives. The fault also sets a latch that holds the pins at 0 until software clears it. Each pin has an override-enable output that tells the port logic to use this block's value in place of its own.

Top module: `pwm_deadtime_ext`

## Requirements
- R1: After reset all pin values are 0, the fault latch is clear, and both active dead-time counts and the active pattern mask are 0.
- R2: Channel c drives pin 2c with its low side, which follows the waveform, and pin 2c+1 with its high side, which is the inverse. The two sides of a channel are never 1 at the same time. In steady state both take their value one clock after the waveform is sampled.
- R3: On a rising waveform edge seen at a clock, the high side goes to 0 at that clock. The low side goes to 1 a number of clocks later equal to the active low-side count. On a falling edge the roles swap and the active high-side count is used. A new edge during a wait restarts the wait.
- R4: With an active count of 0, both sides of a channel change at the same clock, with no gap.
- R5: A dead-time write (high count, low count) or a pattern write goes to a holding register and sets its valid flag. On the update strobe, a held value with its flag set becomes active and the flag clears. A strobe with no flag set leaves the active value unchanged.
- R6: In pattern mode, pin i is driven from a register loaded each clock with active pattern bit i AND the channel-0 waveform. The dead-time counts have no effect on this path.
- R7: While any fault line whose mask bit is 1 is high, every pin value is 0 in the same cycle, and the fault latch sets at the next clock. Fault lines whose mask bit is 0 have no effect.
- R8: A clear request resets the fault latch at the next clock only if no unmasked fault line is high in that cycle. While the latch is set, every pin value is 0.
- R9: The per-pin override-enable output always equals the override-enable input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_in | input | 4 | Waveform bit of each compare channel |
| upd_stb | input | 1 | Timer update strobe, moves held settings to active |
| dt_wr | input | 1 | Write strobe for the dead-time holding register |
| dt_hi_wdata | input | 8 | High-side dead-time count to hold |
| dt_lo_wdata | input | 8 | Low-side dead-time count to hold |
| pat_wr | input | 1 | Write strobe for the pattern holding register |
| pat_wdata | input | 8 | Pattern pin mask to hold |
| pattern_mode | input | 1 | 1 selects pattern output, 0 selects dead-time output |
| ovr_en | input | 8 | Per-pin override enable |
| fault_in | input | 4 | Fault event lines |
| fault_mask | input | 4 | 1 lets the matching fault line trip the stage |
| fault_clr | input | 1 | Request to clear the fault latch |
| pin_val | output | 8 | Pin drive values |
| pin_ovr | output | 8 | Pin override enables |
| fault_active | output | 1 | Fault latch state |

## Verification
The hardest state to reach is a wait that gets cut short or overlaps other activity. One case is a channel still counting out its dead time when pattern mode is switched off, which puts the dead-time path on the pins in the middle of a gap. Another is several channels waiting out different counts in the same cycles. The stimulus loads unequal high and low counts through the holding registers and the update strobe. It then toggles several channels in one cycle, so rising and falling waits overlap. Next it toggles channel 0 under pattern mode and leaves the mode while that channel's high-side wait is still running. Finally it tries to clear the fault while a second fault line is high.

// File: rtl/pwm_ext_pkg.sv
package pwm_ext_pkg;

    typedef enum logic {
        PH_STEADY = 1'b0,
        PH_WAIT   = 1'b1
    } dt_phase_e;

    function automatic int lo_pin(input int ch);
        return 2 * ch;
    endfunction

    function automatic int hi_pin(input int ch);
        return 2 * ch + 1;
    endfunction

endpackage

// File: rtl/pwm_dbl_buf.sv
module pwm_dbl_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         upd_i,
    output logic [W-1:0] act_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic         valid;
        logic [W-1:0] act;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_i && st_q.valid) begin
            st_d.act   = st_q.hold;
            st_d.valid = 1'b0;
        end
        if (wr_i) begin
            st_d.hold  = wdata_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

    // R5: strobe with nothing pending keeps active value
    p_hold_no_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !st_q.valid) |=> (act_o == $past(act_o)));

    // R5: strobe with pending value loads it
    p_load_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && st_q.valid) |=> (act_o == $past(st_q.hold)));

endmodule

// File: rtl/pwm_dt_unit.sv
module pwm_dt_unit
    import pwm_ext_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wave_i,
    input  logic [DT_W-1:0] dt_hi_i,
    input  logic [DT_W-1:0] dt_lo_i,
    output logic            ls_o,
    output logic            hs_o
);
    typedef struct packed {
        logic            lvl;
        logic [DT_W-1:0] cnt;
        dt_phase_e       ph;
        logic            ls;
        logic            hs;
    } dt_t;

    dt_t st_d, st_q;
    logic            edge_seen;
    logic [DT_W-1:0] wait_sel;

    always_comb begin
        st_d      = st_q;
        st_d.lvl  = wave_i;
        edge_seen = (wave_i != st_q.lvl);
        wait_sel  = wave_i ? dt_lo_i : dt_hi_i;

        if (edge_seen && (wait_sel != '0)) begin
            st_d.ls  = 1'b0;
            st_d.hs  = 1'b0;
            st_d.cnt = wait_sel;
            st_d.ph  = PH_WAIT;
        end else if (!edge_seen && (st_q.ph == PH_WAIT) && (st_q.cnt > 1)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.ls  = wave_i;
            st_d.hs  = ~wave_i;
            st_d.cnt = '0;
            st_d.ph  = PH_STEADY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: 1'b0, cnt: '0, ph: PH_STEADY, ls: 1'b0, hs: 1'b0};
        else        st_q <= st_d;
    end

    assign ls_o = st_q.ls;
    assign hs_o = st_q.hs;

    // R2: sides of one channel never on together
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_o && hs_o));

    // R3: an edge with nonzero wait opens a gap on both sides
    p_dead_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && (wait_sel != '0)) |=> (!ls_o && !hs_o));

endmodule

// File: rtl/pwm_fault_latch.sv
module pwm_fault_latch #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] fault_i,
    input  logic [NF-1:0] mask_i,
    input  logic          clr_i,
    output logic          hit_o,
    output logic          latched_o
);
    typedef struct packed {
        logic latched;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        hit_o = |(fault_i & mask_i);
        if (hit_o)      st_d.latched = 1'b1;
        else if (clr_i) st_d.latched = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched_o = st_q.latched;

    // R7: an unmasked fault sets the latch next clock
    p_fault_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> latched_o);

    // R8: latch only drops after a clear request
    p_clear_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && !clr_i) |=> latched_o);

endmodule

// File: rtl/pwm_deadtime_ext.sv
module pwm_deadtime_ext
    import pwm_ext_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DT_W      = 8,
    parameter int NUM_FAULT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      wave_in,
    input  logic                   upd_stb,
    input  logic                   dt_wr,
    input  logic [DT_W-1:0]        dt_hi_wdata,
    input  logic [DT_W-1:0]        dt_lo_wdata,
    input  logic                   pat_wr,
    input  logic [2*NUM_CH-1:0]    pat_wdata,
    input  logic                   pattern_mode,
    input  logic [2*NUM_CH-1:0]    ovr_en,
    input  logic [NUM_FAULT-1:0]   fault_in,
    input  logic [NUM_FAULT-1:0]   fault_mask,
    input  logic                   fault_clr,
    output logic [2*NUM_CH-1:0]    pin_val,
    output logic [2*NUM_CH-1:0]    pin_ovr,
    output logic                   fault_active
);
    localparam int NUM_PIN = 2 * NUM_CH;
    localparam int DTP_W   = 2 * DT_W;

    typedef struct packed {
        logic [NUM_PIN-1:0] pat_out;
    } top_t;

    top_t st_d, st_q;

    logic [DTP_W-1:0]   dt_act;
    logic [DT_W-1:0]    dt_hi_act, dt_lo_act;
    logic [NUM_PIN-1:0] pat_act;
    logic [NUM_PIN-1:0] dt_pins;
    logic               fault_hit;

    pwm_dbl_buf #(.W(DTP_W)) u_dt_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (dt_wr),
        .wdata_i ({dt_hi_wdata, dt_lo_wdata}),
        .upd_i   (upd_stb),
        .act_o   (dt_act)
    );

    assign dt_hi_act = dt_act[DTP_W-1:DT_W];
    assign dt_lo_act = dt_act[DT_W-1:0];

    pwm_dbl_buf #(.W(NUM_PIN)) u_pat_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (pat_wr),
        .wdata_i (pat_wdata),
        .upd_i   (upd_stb),
        .act_o   (pat_act)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_dt_unit #(.DT_W(DT_W)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wave_i  (wave_in[c]),
            .dt_hi_i (dt_hi_act),
            .dt_lo_i (dt_lo_act),
            .ls_o    (dt_pins[lo_pin(c)]),
            .hs_o    (dt_pins[hi_pin(c)])
        );
    end

    pwm_fault_latch #(.NF(NUM_FAULT)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_i   (fault_in),
        .mask_i    (fault_mask),
        .clr_i     (fault_clr),
        .hit_o     (fault_hit),
        .latched_o (fault_active)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pat_out = pat_act & {NUM_PIN{wave_in[0]}};
        if (fault_hit || fault_active) pin_val = '0;
        else if (pattern_mode)         pin_val = st_q.pat_out;
        else                           pin_val = dt_pins;
        pin_ovr = ovr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: latched fault keeps every pin low
    p_fault_pins_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_active |-> (pin_val == '0));

    // R7: a live unmasked fault keeps every pin low
    p_fault_live_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |-> (pin_val == '0));

endmodule

// File: tb/pwm_deadtime_ext_test.sv
module pwm_deadtime_ext_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] wave = '0;
    logic       upd = 1'b0;
    logic       dtw = 1'b0;
    logic [7:0] dthi = '0;
    logic [7:0] dtlo = '0;
    logic       patw = 1'b0;
    logic [7:0] patd = '0;
    logic       pmode = 1'b0;
    logic [7:0] ovr = 8'hFF;
    logic [3:0] flt = '0;
    logic [3:0] fmask = 4'hF;
    logic       fclr = 1'b0;
    logic [7:0] pin_val, pin_ovr;
    logic       fault_active;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_deadtime_ext uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wave_in      (wave),
        .upd_stb      (upd),
        .dt_wr        (dtw),
        .dt_hi_wdata  (dthi),
        .dt_lo_wdata  (dtlo),
        .pat_wr       (patw),
        .pat_wdata    (patd),
        .pattern_mode (pmode),
        .ovr_en       (ovr),
        .fault_in     (flt),
        .fault_mask   (fmask),
        .fault_clr    (fclr),
        .pin_val      (pin_val),
        .pin_ovr      (pin_ovr),
        .fault_active (fault_active)
    );

    task automatic nxt();
        @(negedge clk);
    endtask

    // driver side: queue the expected outputs for this cycle's sample
    task automatic chk(input logic [7:0] v, input logic f, input string req);
        exp_q.push_back({f, ovr, v});
        tag_q.push_back(req);
    endtask

    // monitor side: sample a quarter period after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({fault_active, pin_ovr, pin_val} !== e) begin
                    failures++;
                    $display("FAIL %s: got flt=%0b ovr=%h val=%h expected flt=%0b ovr=%h val=%h",
                             t, fault_active, pin_ovr, pin_val, e[16], e[15:8], e[7:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        nxt(); chk(8'h00, 1'b0, "R1 in reset");
        nxt(); rst_n = 1'b1; chk(8'h00, 1'b0, "R1 after release");
        nxt(); chk(8'hAA, 1'b0, "R2 high sides on");
        nxt(); wave = 4'b0001; chk(8'hAA, 1'b0, "R2");
        nxt(); chk(8'hA9, 1'b0, "R4 R1 zero count no gap");
        nxt(); dtw = 1'b1; dthi = 8'd3; dtlo = 8'd2; wave = 4'b0000; chk(8'hA9, 1'b0, "R2");
        nxt(); dtw = 1'b0; chk(8'hAA, 1'b0, "R5 write held until strobe");
        nxt(); upd = 1'b1; chk(8'hAA, 1'b0, "R2");
        nxt(); upd = 1'b0; wave = 4'b0001; chk(8'hAA, 1'b0, "R2");
        nxt(); chk(8'hA8, 1'b0, "R3 rise gap 1");
        nxt(); chk(8'hA8, 1'b0, "R3 rise gap 2");
        nxt(); wave = 4'b0000; chk(8'hA9, 1'b0, "R3 low side on after 2");
        nxt(); chk(8'hA8, 1'b0, "R3 fall gap 1");
        nxt(); chk(8'hA8, 1'b0, "R3 fall gap 2");
        nxt(); chk(8'hA8, 1'b0, "R3 fall gap 3");
        nxt(); upd = 1'b1; chk(8'hAA, 1'b0, "R3 high side on after 3");
        nxt(); upd = 1'b0; wave = 4'b0001; chk(8'hAA, 1'b0, "R5");
        nxt(); chk(8'hA8, 1'b0, "R5 empty strobe kept counts");
        nxt(); chk(8'hA8, 1'b0, "R5 empty strobe kept counts");
        nxt(); wave = 4'b1010; chk(8'hA9, 1'b0, "R5 empty strobe kept counts");
        nxt(); chk(8'h20, 1'b0, "R3 multi-channel gap");
        nxt(); chk(8'h20, 1'b0, "R3 multi-channel gap");
        nxt(); chk(8'h64, 1'b0, "R3 rising channels on");
        nxt(); patw = 1'b1; patd = 8'hC5; chk(8'h66, 1'b0, "R3 falling channel on");
        nxt(); patw = 1'b0; upd = 1'b1; pmode = 1'b1; chk(8'h00, 1'b0, "R6 pattern not yet active");
        nxt(); upd = 1'b0; wave = 4'b1011; chk(8'h00, 1'b0, "R6 waveform low");
        nxt(); wave = 4'b1010; chk(8'hC5, 1'b0, "R6 pattern follows channel 0");
        nxt(); pmode = 1'b0; chk(8'h64, 1'b0, "R6 leaving pattern mid wait");
        nxt();
        nxt();
        nxt(); chk(8'h66, 1'b0, "R3 wait finished");
        nxt(); flt = 4'b0100; chk(8'h00, 1'b0, "R7 immediate shutdown");
        nxt(); flt = 4'b0000; chk(8'h00, 1'b1, "R7 latched");
        nxt(); flt = 4'b0010; fclr = 1'b1; chk(8'h00, 1'b1, "R8");
        nxt(); flt = 4'b0000; chk(8'h00, 1'b1, "R8 clear blocked by live fault");
        nxt(); fclr = 1'b0; chk(8'h66, 1'b0, "R8 cleared");
        nxt(); fmask = 4'b1110; flt = 4'b0001; chk(8'h66, 1'b0, "R7 masked line ignored");
        nxt(); flt = 4'b0000; ovr = 8'h5A; chk(8'h66, 1'b0, "R7 R9 no latch, override passthrough");
        nxt(); ovr = 8'h0F; chk(8'h66, 1'b0, "R9");
        nxt();
        nxt();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule